// File: doc/BRIEF.md
# Threshold-Triggered Clock Phase Realigner

This block runs on a fast oversampling clock and produces a recovered sampling clock for an incoming serial data stream. The recovered clock is a square wave whose high and low halves each last a configured number of oversampling ticks. Every rising edge of the (synchronized) data starts a tick count, and the count stops at the next rising edge of the recovered clock. That delay is published as the phase error.

When a freshly measured error is strictly larger than a programmable threshold, the block drops its free-running toggling. It keeps the recovered clock high for a number of extra ticks equal to the error, then drives it low, clears the error and resumes normal toggling from a fresh half period. The whole measured delay is applied in a single stretch of the high phase; there is no gradual stepping. Data edges that arrive during a stretch are not measured, so a correction cannot trigger itself again.

Top module: `clk_phase_realigner`

## Requirements
- R1: On a clock edge with `rst` high (synchronous, active high), `rclk_out` becomes 0, `phase_err` becomes 0 and `corr_busy` becomes 0.
- R2: Outside a correction, `rclk_out` toggles every `half_len` clock edges, so each high and each low half lasts `half_len` edges (values below 2 act as 2). The first rising edge comes `half_len` edges after the last reset edge.
- R3: `din` passes through a two-flop synchronizer. Only its 0-to-1 transitions start a measurement, and a falling `din` leaves `phase_err` unchanged.
- R4: Let Ed be the clock edge at which `din` is first sampled high, and Kr the first edge at or after Ed+2 after which `rclk_out` reads 1. Then E = Kr - Ed - 2, and it appears on `phase_err` after edge Kr+1. Every new rising data edge produces a new measurement.
- R5: The measured error saturates at 2^EW-1 (255 with the default EW=8).
- R6: A correction starts only when E > `thresh` (strict). `corr_busy` then rises after edge Kr+2. When E <= `thresh`, `corr_busy` stays 0 and normal toggling continues.
- R7: During a correction `rclk_out` stays 1. It falls after edge Kr+2+E, and `corr_busy` falls on the same edge.
- R8: `phase_err` reads 0 after the edge that ends a correction.
- R9: After a correction, the next rising edge of `rclk_out` comes exactly `half_len` edges after its fall.
- R10: Rising data edges that are detected while `corr_busy` is 1 are not measured. `phase_err` stays 0 and no further correction follows until a new data edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Incoming serial data, asynchronous |
| half_len | input | CW | Ticks per half period of the recovered clock |
| thresh | input | EW | Phase error threshold for a correction |
| rclk_out | output | 1 | Recovered clock |
| phase_err | output | EW | Most recent measured phase error, in ticks |
| corr_busy | output | 1 | High while the high phase is being stretched |

## Verification
The hardest situation to reach from the ports is a rising data edge that is detected in the middle of a stretch. Two timing conditions must hold together: the error must be large enough that the stretch lasts past the synchronizer latency, and the new edge must land strictly inside it. The bench aligns every stimulus to an observed rising edge of `rclk_out`. It places the data edge d ticks later, which gives E = 2*half_len - d - 3. It then toggles `din` low and high a fixed number of cycles into the stretch. The same offset arithmetic drives the error to exactly the threshold and to one above it, and with a long half period it drives the counter into saturation.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic {GEN_RUN = 1'b0, GEN_EXT = 1'b1} gen_state_e;
  localparam int unsigned PR_MIN_HALF = 2;
endpackage

// File: rtl/pr_din_sync.sv
module pr_din_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic data_rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_d <= 1'b0;
    else     last_d <= chain[LAST];
  end

  assign data_rise = chain[LAST] & ~last_d;
endmodule

// File: rtl/pr_phase_meter.sv
module pr_phase_meter #(
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_rise,
  input  logic          rclk,
  input  logic          busy,
  input  logic          clear,
  output logic [EW-1:0] err,
  output logic          done
);
  localparam logic [EW-1:0] SAT = {EW{1'b1}};

  logic          rclk_d;
  logic          running;
  logic [EW-1:0] acc;
  logic          rclk_rise;

  assign rclk_rise = rclk & ~rclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_d  <= 1'b0;
      running <= 1'b0;
      acc     <= '0;
      err     <= '0;
      done    <= 1'b0;
    end else begin
      rclk_d <= rclk;
      done   <= 1'b0;
      if (busy) begin
        running <= 1'b0;
      end else if (data_rise) begin
        running <= 1'b1;
        acc     <= '0;
      end else if (running) begin
        if (rclk_rise) begin
          err     <= acc;
          done    <= 1'b1;
          running <= 1'b0;
        end else if (acc != SAT) begin
          acc <= acc + 1'b1;
        end
      end
      if (clear) err <= '0;
    end
  end
endmodule

// File: rtl/pr_clk_gen.sv
module pr_clk_gen
  import pr_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] half_len,
  input  logic [EW-1:0] thresh,
  input  logic          done,
  input  logic [EW-1:0] err,
  output logic          rclk,
  output logic          busy,
  output logic          finish
);
  localparam logic [CW-1:0] MIN_LIM = CW'(PR_MIN_HALF - 1);

  gen_state_e    state;
  logic [CW-1:0] hcnt;
  logic [CW-1:0] lim;
  logic [EW-1:0] ecnt;
  logic [EW-1:0] elen;

  assign lim    = (half_len < CW'(PR_MIN_HALF)) ? MIN_LIM : (half_len - 1'b1);
  assign finish = (state == GEN_EXT) && (ecnt == elen);
  assign busy   = (state == GEN_EXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GEN_RUN;
      rclk  <= 1'b0;
      hcnt  <= '0;
      ecnt  <= '0;
      elen  <= '0;
    end else begin
      case (state)
        GEN_RUN: begin
          if (done && (err > thresh)) begin
            state <= GEN_EXT;
            rclk  <= 1'b1;
            ecnt  <= EW'(1);
            elen  <= err;
          end else if (hcnt >= lim) begin
            hcnt <= '0;
            rclk <= ~rclk;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        GEN_EXT: begin
          if (finish) begin
            state <= GEN_RUN;
            rclk  <= 1'b0;
            hcnt  <= '0;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        default: state <= GEN_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clk_phase_realigner.sv
module clk_phase_realigner #(
  parameter int unsigned CW          = 8,
  parameter int unsigned EW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [CW-1:0] half_len,
  input  logic [EW-1:0] thresh,
  output logic          rclk_out,
  output logic [EW-1:0] phase_err,
  output logic          corr_busy
);
  logic          data_rise;
  logic          meas_done;
  logic          ext_end;
  logic          rclk_q;
  logic          busy_q;
  logic [EW-1:0] err_q;

  pr_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .data_rise (data_rise)
  );

  pr_phase_meter #(.EW(EW)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .data_rise (data_rise),
    .rclk      (rclk_q),
    .busy      (busy_q),
    .clear     (ext_end),
    .err       (err_q),
    .done      (meas_done)
  );

  pr_clk_gen #(.CW(CW), .EW(EW)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .half_len (half_len),
    .thresh   (thresh),
    .done     (meas_done),
    .err      (err_q),
    .rclk     (rclk_q),
    .busy     (busy_q),
    .finish   (ext_end)
  );

  assign rclk_out  = rclk_q;
  assign phase_err = err_q;
  assign corr_busy = busy_q;
endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
  parameter int unsigned EW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rclk_out,
  input logic [EW-1:0] phase_err,
  input logic [EW-1:0] thresh,
  input logic          corr_busy
);
  // R1: state right after a reset edge
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rclk_out && !corr_busy && phase_err == '0));

  // R6: a correction only begins on an error above the threshold
  a_r6_start_above_thresh: assert property (@(posedge clk) disable iff (rst)
    $rose(corr_busy) |-> (rclk_out && ($past(phase_err) > $past(thresh))));

  // R7: clock held high for the whole correction
  a_r7_high_while_busy: assert property (@(posedge clk) disable iff (rst)
    corr_busy |-> rclk_out);

  // R7: a correction ends with the clock going low
  a_r7_end_low: assert property (@(posedge clk) disable iff (rst)
    corr_busy |=> (corr_busy || !rclk_out));

  // R8: error cleared when the correction ends
  a_r8_clear_on_end: assert property (@(posedge clk) disable iff (rst)
    $fell(corr_busy) |-> (phase_err == '0));

  // R10: no new measurement lands during a correction
  a_r10_no_update_busy: assert property (@(posedge clk) disable iff (rst)
    corr_busy |=> (!corr_busy || $stable(phase_err)));
endmodule

bind clk_phase_realigner pr_checker #(.EW(EW)) u_pr_checker (
  .clk       (clk),
  .rst       (rst),
  .rclk_out  (rclk_out),
  .phase_err (phase_err),
  .thresh    (thresh),
  .corr_busy (corr_busy)
);

// File: tb/clk_phase_realigner_test.sv
module clk_phase_realigner_test;
  localparam int CW  = 8;
  localparam int EW  = 8;
  localparam int SAT = 255;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          din = 1'b0;
  logic [CW-1:0] half_len = 8'd8;
  logic [EW-1:0] thresh = 8'd255;
  logic          rclk_out;
  logic [EW-1:0] phase_err;
  logic          corr_busy;

  int cyc   = 0;
  int n_chk = 0;
  int n_bad = 0;

  clk_phase_realigner #(.CW(CW), .EW(EW), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .half_len  (half_len),
    .thresh    (thresh),
    .rclk_out  (rclk_out),
    .phase_err (phase_err),
    .corr_busy (corr_busy)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic upto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_edge(input logic lvl, output int k);
    logic prev;
    bit   found;
    prev  = rclk_out;
    found = 0;
    while (!found) begin
      @(negedge clk);
      if (rclk_out == lvl && prev != lvl) begin
        k     = cyc;
        found = 1;
      end
      prev = rclk_out;
    end
  endtask

  task automatic do_reset(input int h, output int last_rst);
    @(negedge clk);
    rst      = 1'b1;
    din      = 1'b0;
    half_len = CW'(h);
    step(2);
    last_rst = cyc;
    rst      = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    step(2);
    chk("R1 rclk_out in reset", int'(rclk_out), 0);
    chk("R1 phase_err in reset", int'(phase_err), 0);
    chk("R1 corr_busy in reset", int'(corr_busy), 0);
  endtask

  task automatic t_free(input int h);
    int r0, r1, f1, r2;
    do_reset(h, r0);
    wait_edge(1'b1, r1);
    chk("R2 first rise after reset", r1 - r0, h);
    wait_edge(1'b0, f1);
    wait_edge(1'b1, r2);
    chk("R2 high half length", f1 - r1, h);
    chk("R2 low half length", r2 - f1, h);
  endtask

  // data edge placed d ticks after an observed rise; no correction expected
  task automatic t_measure(input int h, input int d, input int thr, output int e);
    int kr, ed, k2;
    thresh = EW'(thr);
    din    = 1'b0;
    step(3);
    wait_edge(1'b1, kr);
    upto(kr + d);
    din = 1'b1;
    ed  = cyc + 1;
    wait_edge(1'b1, k2);
    chk("R2 rise spacing around measurement", k2 - kr, 2 * h);
    e = k2 - ed - 2;
    if (e > SAT) e = SAT;
    upto(k2 + 1);
    chk("R4/R5 measured phase_err", int'(phase_err), e);
    upto(k2 + 2);
    chk("R6 no correction when error <= thresh", int'(corr_busy), 0);
  endtask

  task automatic t_correct(input int h, input int d, input int thr, input bit noise);
    int kr, ed, k2, k3, e;
    thresh = EW'(thr);
    din    = 1'b0;
    step(3);
    wait_edge(1'b1, kr);
    upto(kr + d);
    din = 1'b1;
    ed  = cyc + 1;
    wait_edge(1'b1, k2);
    e = k2 - ed - 2;
    upto(k2 + 1);
    chk("R4 error before correction", int'(phase_err), e);
    chk("R6 busy not yet", int'(corr_busy), 0);
    upto(k2 + 2);
    chk("R6 correction started", int'(corr_busy), 1);
    chk("R7 clock high at start", int'(rclk_out), 1);
    if (noise) begin
      upto(k2 + 3);
      din = 1'b0;
      upto(k2 + 6);
      din = 1'b1;
    end
    upto(k2 + 1 + e);
    chk("R7 clock still high last stretch tick", int'(rclk_out), 1);
    chk("R7 busy still high last stretch tick", int'(corr_busy), 1);
    upto(k2 + 2 + e);
    chk("R7 clock low after stretch", int'(rclk_out), 0);
    chk("R7 busy low after stretch", int'(corr_busy), 0);
    chk("R8 error cleared", int'(phase_err), 0);
    wait_edge(1'b1, k3);
    chk("R9 rise one half period after fall", k3 - (k2 + 2 + e), h);
    if (noise) begin
      upto(k3 + 2);
      chk("R10 edge during stretch not measured", int'(phase_err), 0);
      chk("R10 no retrigger", int'(corr_busy), 0);
    end
  endtask

  task automatic t_fall_ignored();
    int e1, k;
    t_measure(8, 4, 255, e1);
    din = 1'b0;
    wait_edge(1'b1, k);
    upto(k + 2);
    chk("R3 falling din leaves phase_err", int'(phase_err), e1);
  endtask

  initial begin
    int r, e;
    t_reset();
    t_free(5);
    t_free(9);
    do_reset(8, r);
    t_measure(8, 1, 255, e);
    chk("R4 offset 1 value", e, 12);
    t_measure(8, 4, 255, e);
    chk("R4 offset 4 value", e, 9);
    t_measure(8, 10, 255, e);
    chk("R4 offset 10 value", e, 3);
    t_measure(8, 13, 255, e);
    chk("R4 offset 13 value", e, 0);
    t_measure(8, 2, 11, e);
    chk("R6 error equal to thresh", e, 11);
    t_correct(8, 2, 10, 1'b0);
    t_correct(8, 2, 5, 1'b1);
    t_fall_ignored();
    do_reset(200, r);
    t_measure(200, 2, 255, e);
    chk("R5 saturated value", e, SAT);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule